// File: doc/BRIEF.md
# Flash Program/Erase Status Byte Generator

This block models the device side of a parallel NOR flash while an internal program or erase is running. Each read qualified by the output-enable or the chip-enable strobe returns one byte. While an operation is running, or after one has failed, that byte is a status word and not array data. Two independent toggle bits are present. The operation toggle (bit 6) flips on every status read while an operation actively runs. The sector toggle (bit 2) flips on every status read whose address lands in a sector chosen for erase, whether the erase is running or suspended. The host compares two consecutive reads to learn both the operating mode and whether the addressed sector is involved in the erase.

The block holds an internal pulse counter. While the environment reports a stalled operation, for example a program of a 1 over a stored 0, the counter advances once per clock. When it reaches the limit, a sticky failure flag sets and appears as bit 5. The failure keeps the block in status mode until a reset command (data 8'hF0 on a write, at any address) is accepted. Reset returns the block to array read, or to erase-suspend read if an erase was suspended underneath the failed program. Bit 3 mirrors the "erase has begun" input.

The read path is a one-beat response stream. `dout_valid_o` pulses in the cycle after each qualified read, with `dout_o` valid in that cycle. The stream has no ready input and cannot be back-pressured: the host must take the byte in that cycle. A read strobe may arrive in every cycle.

Top module: `nor_status_gen`

## Requirements
- R1: A cycle in which `rd_oe_i` or `rd_ce_i` (or both) is high is one read. In the next cycle `dout_valid_o` is 1 and `dout_o` holds the response. In all other cycles `dout_valid_o` is 0.
- R2: The status byte carries the operation toggle in bit 6. Each status read while `busy_i` or the failure flag is 1 returns the current value and inverts it. Otherwise the bit holds, including during erase-suspend status reads. Its reset value is 0.
- R3: The status byte carries the sector toggle in bit 2. A status read whose sector (the top SECT_W address bits) has its `sect_sel_i` flag set, while `erase_act_i` or `erase_susp_i` is 1, returns the bit and inverts it. Otherwise the bit holds. Its reset value is 0.
- R4: After PULSE_LIMIT consecutive clocks with `busy_i` and `stuck_i` both 1, `fail_o` becomes 1. Bit 5 of the status byte equals `fail_o`.
- R5: `fail_o` stays 1 until a write with data 8'hF0. A write of any other data is ignored. A write of 8'hF0 while busy and not failed is ignored and does not restart the pulse count.
- R6: Bit 3 of the status byte equals `erase_begun_i`. Bits 7, 4, 1 and 0 of the status byte read 0.
- R7: A read returns `array_data_i` unchanged when `busy_i` is 0, the block has not failed, and it is not an erase-suspend read of a selected sector. An erase-suspend read of a selected sector returns the status byte.
- R8: `mode_o` is 1 (status) while busy or failed. Otherwise it is 2 (erase-suspend read) while `erase_susp_i` is 1, and 0 (array read) in all other cases. An accepted reset from a failure during a suspended erase gives mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_oe_i | input | 1 | Read qualified by output enable |
| rd_ce_i | input | 1 | Read qualified by chip enable |
| rd_addr_i | input | ADDR_W | Read address; top SECT_W bits pick the sector |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | 8 | Command write data |
| busy_i | input | 1 | A program or erase is actively running |
| erase_act_i | input | 1 | An erase is actively running |
| erase_susp_i | input | 1 | An erase is suspended |
| erase_begun_i | input | 1 | The sector erase has begun |
| stuck_i | input | 1 | The running operation is stalled |
| sect_sel_i | input | 2**SECT_W | Per-sector erase-selected flags |
| array_data_i | input | 8 | Array data for normal reads |
| dout_o | output | 8 | Read response byte |
| dout_valid_o | output | 1 | Response valid, one cycle after a read |
| fail_o | output | 1 | Sticky operation failure |
| mode_o | output | 2 | 0 array read, 1 status, 2 erase-suspend read |

## Verification
A toggle register that is stuck, or that flips under the wrong condition, breaks the alternation between two consecutive reads. This shows on `dout_o` at the second read, one cycle after its strobe. A pulse counter that is off by one moves the rise of `fail_o` by a clock, and the bench samples the clock before and the clock at the limit. A failure latch that clears when it should not is visible at once on `fail_o` and `mode_o`, and in bit 5 on the next read.

// File: rtl/nor_stat_pkg.sv
package nor_stat_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_SUSP   = 2'd2
  } rd_mode_e;

  localparam logic [7:0] CMD_RESET = 8'hF0;
endpackage

// File: rtl/nsg_toggle_bit.sv
module nsg_toggle_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else if (flip_i) q_o <= ~q_o;
  end

  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    flip_i |=> (q_o != $past(q_o))); // R2
  AST_TOGGLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !flip_i |=> $stable(q_o)); // R3
endmodule

// File: rtl/nsg_timeout_mon.sv
module nsg_timeout_mon #(
  parameter int PULSE_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en_i,
  input  logic clear_i,
  output logic fail_o
);
  localparam int CW = $clog2(PULSE_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(PULSE_LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(PULSE_LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fail_o <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      fail_o <= 1'b0;
    end else if (fail_o) begin
      cnt_q  <= cnt_q;
    end else if (count_en_i) begin
      if (cnt_q == LAST) begin
        cnt_q  <= TOP;
        fail_o <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R4
  AST_FAIL_NEEDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> $past(count_en_i)); // R4
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clear_i) |=> fail_o); // R5
endmodule

// File: rtl/nsg_sector_pick.sv
module nsg_sector_pick #(
  parameter int ADDR_W = 8,
  parameter int SECT_W = 2
) (
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [(1<<SECT_W)-1:0] sel_i,
  output logic                   hit_o
);
  localparam int SHIFT = ADDR_W - SECT_W;
  logic [SECT_W-1:0] idx;

  always_comb begin
    idx   = SECT_W'(addr_i >> SHIFT);
    hit_o = sel_i[idx];
  end
endmodule

// File: rtl/nor_status_gen.sv
module nor_status_gen
  import nor_stat_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SECT_W      = 2,
  parameter int PULSE_LIMIT = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rd_oe_i,
  input  logic                   rd_ce_i,
  input  logic [ADDR_W-1:0]      rd_addr_i,
  input  logic                   wr_en_i,
  input  logic [7:0]             wr_data_i,
  input  logic                   busy_i,
  input  logic                   erase_act_i,
  input  logic                   erase_susp_i,
  input  logic                   erase_begun_i,
  input  logic                   stuck_i,
  input  logic [(1<<SECT_W)-1:0] sect_sel_i,
  input  logic [7:0]             array_data_i,
  output logic [7:0]             dout_o,
  output logic                   dout_valid_o,
  output logic                   fail_o,
  output logic [1:0]             mode_o
);
  logic rd_evt, sec_hit, rst_cmd;
  logic st_full, st_susp, status_rd;
  logic op_flip, sec_flip, op_tog, sec_tog;
  logic [7:0] status_byte;

  nsg_sector_pick #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_pick (
    .addr_i (rd_addr_i),
    .sel_i  (sect_sel_i),
    .hit_o  (sec_hit)
  );

  nsg_timeout_mon #(.PULSE_LIMIT(PULSE_LIMIT)) u_tmo (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_en_i (busy_i & stuck_i),
    .clear_i    (rst_cmd),
    .fail_o     (fail_o)
  );

  always_comb begin
    rd_evt    = rd_oe_i | rd_ce_i;
    rst_cmd   = wr_en_i && (wr_data_i == CMD_RESET) && (fail_o || !busy_i);
    st_full   = busy_i | fail_o;
    st_susp   = !st_full && erase_susp_i && sec_hit;
    status_rd = rd_evt && (st_full || st_susp);
    op_flip   = status_rd && st_full;
    sec_flip  = status_rd && sec_hit && (erase_act_i || erase_susp_i);
    status_byte = {1'b0, op_tog, fail_o, 1'b0, erase_begun_i, sec_tog, 2'b00};
    if (st_full)           mode_o = MODE_STATUS;
    else if (erase_susp_i) mode_o = MODE_SUSP;
    else                   mode_o = MODE_ARRAY;
  end

  nsg_toggle_bit u_op_tog (
    .clk (clk), .rst_n (rst_n), .flip_i (op_flip), .q_o (op_tog)
  );

  nsg_toggle_bit u_sec_tog (
    .clk (clk), .rst_n (rst_n), .flip_i (sec_flip), .q_o (sec_tog)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_o       <= 8'h00;
      dout_valid_o <= 1'b0;
    end else begin
      dout_valid_o <= rd_evt;
      if (rd_evt) dout_o <= status_rd ? status_byte : array_data_i;
    end
  end

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid_o |-> $past(rd_evt)); // R1
  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && mode_o == MODE_ARRAY) |=> (dout_o == $past(array_data_i))); // R7
  AST_OP_TOG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !fail_o) |=> $stable(op_tog)); // R2
  AST_FAIL_STATUS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (mode_o == MODE_STATUS)); // R8
endmodule

// File: tb/nor_status_gen_bench.sv
module nor_status_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_oe = 0, rd_ce = 0, wr_en = 0;
  logic [7:0] rd_addr = 0, wr_data = 0, array_data = 0;
  logic busy = 0, erase_act = 0, erase_susp = 0, erase_begun = 0, stuck = 0;
  logic [3:0] sect_sel = 0;
  logic [7:0] dout;
  logic dout_valid, fail;
  logic [1:0] mode;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_status_gen #(.ADDR_W(8), .SECT_W(2), .PULSE_LIMIT(LIMIT)) u_nor_status_gen (
    .clk(clk), .rst_n(rst_n), .rd_oe_i(rd_oe), .rd_ce_i(rd_ce),
    .rd_addr_i(rd_addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .busy_i(busy), .erase_act_i(erase_act), .erase_susp_i(erase_susp),
    .erase_begun_i(erase_begun), .stuck_i(stuck), .sect_sel_i(sect_sel),
    .array_data_i(array_data), .dout_o(dout), .dout_valid_o(dout_valid),
    .fail_o(fail), .mode_o(mode)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input bit use_ce, input logic [7:0] addr,
                        input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_addr = addr; rd_oe = !use_ce; rd_ce = use_ce;
    @(negedge clk);
    rd_oe = 0; rd_ce = 0;
    check(dout_valid === 1'b1, "R1 valid", dout_valid, 1);
    check(dout === exp, tag, dout, exp);
    @(negedge clk);
    check(dout_valid === 1'b0, "R1 valid drop", dout_valid, 0);
  endtask

  task automatic cmd_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset_state;
    check(dout_valid === 1'b0, "R1 reset valid", dout_valid, 0);
    check(fail === 1'b0, "R4 reset fail", fail, 0);
    check(mode === 2'd0, "R8 reset mode", mode, 0);
  endtask

  task automatic t_array_read;
    array_data = 8'hA5;
    rd_chk(1'b1, 8'h10, 8'hA5, "R7 array via ce");
    array_data = 8'h5A;
    rd_chk(1'b0, 8'hC0, 8'h5A, "R7 array via oe");
  endtask

  task automatic t_program;
    busy = 1;
    @(negedge clk);
    check(mode === 2'd1, "R8 busy mode", mode, 1);
    rd_chk(1'b0, 8'h10, 8'h00, "R2 prog read1");
    rd_chk(1'b1, 8'h10, 8'h40, "R2 prog read2");
    rd_chk(1'b0, 8'h10, 8'h00, "R6 prog read3 zero bits");
    rd_chk(1'b1, 8'h10, 8'h40, "R2 prog read4");
  endtask

  task automatic t_erase;
    erase_act = 1; erase_begun = 1; sect_sel = 4'b0010;
    rd_chk(1'b0, 8'h40, 8'h08, "R3 erase sel sector read1");
    rd_chk(1'b0, 8'h10, 8'h4C, "R3 erase unsel sector holds");
    rd_chk(1'b1, 8'h40, 8'h0C, "R6 erase sel sector read2");
  endtask

  task automatic t_suspend;
    busy = 0; erase_act = 0; erase_susp = 1; array_data = 8'h3C;
    @(negedge clk);
    check(mode === 2'd2, "R8 suspend mode", mode, 2);
    rd_chk(1'b0, 8'h40, 8'h48, "R2 suspend op toggle holds");
    rd_chk(1'b0, 8'h40, 8'h4C, "R3 suspend sector toggles");
    rd_chk(1'b1, 8'h10, 8'h3C, "R7 suspend unsel sector array");
  endtask

  task automatic t_timeout_suspended;
    erase_begun = 0;
    @(negedge clk);
    busy = 1; stuck = 1;
    repeat (LIMIT - 1) @(negedge clk);
    check(fail === 1'b0, "R4 before limit", fail, 0);
    @(negedge clk);
    check(fail === 1'b1, "R4 at limit", fail, 1);
    busy = 0; stuck = 0;
    @(negedge clk);
    check(mode === 2'd1, "R8 failed mode", mode, 1);
    rd_chk(1'b0, 8'h10, 8'h60, "R4 failed status bit5");
    rd_chk(1'b1, 8'h10, 8'h20, "R2 failed op toggles");
    cmd_write(8'hF0);
    check(fail === 1'b0, "R5 reset clears", fail, 0);
    check(mode === 2'd2, "R8 reset to suspend read", mode, 2);
  endtask

  task automatic t_reset_rules;
    erase_susp = 0; sect_sel = 0;
    @(negedge clk);
    busy = 1; stuck = 1;
    repeat (5) @(negedge clk);
    wr_en = 1; wr_data = 8'hF0;
    @(negedge clk);
    wr_en = 0;
    repeat (LIMIT - 7) @(negedge clk);
    check(fail === 1'b0, "R5 busy reset ignored early", fail, 0);
    @(negedge clk);
    check(fail === 1'b1, "R5 busy reset no restart", fail, 1);
    busy = 0; stuck = 0;
    cmd_write(8'h00);
    check(fail === 1'b1, "R5 wrong data ignored", fail, 1);
    cmd_write(8'hF0);
    check(fail === 1'b0, "R5 reset accepted", fail, 0);
    check(mode === 2'd0, "R8 reset to array", mode, 0);
    array_data = 8'h96;
    rd_chk(1'b0, 8'h80, 8'h96, "R7 array after reset");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_array_read();
    t_program();
    t_erase();
    t_suspend();
    t_timeout_suspended();
    t_reset_rules();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule